// File: doc/BRIEF.md
# Sampling Tap Window Selector

After a tuning sweep, a host controller knows for every sampling-clock phase tap whether a probe at that tap passed. The sweep covers the taps twice, so the result is a vector of 2×N bits, where bit i and bit i+N describe the same physical tap. This block stores that vector and, on a start pulse, treats a tap as good only when both of its copies passed. It then walks the merged bits one per clock to find the longest unbroken stretch of good taps and picks the tap at its centre.

The centre index is reduced modulo N. This lets a window that runs across the seam between the two sweeps still land on a real tap. When the best stretch is shorter than a minimum length, the block raises an error and keeps the tap it held before. On success it pulses a set-tap strobe that carries the value to apply, together with a strobe that enables automatic re-tuning. In the halved-tap double-data-rate mode, the applied value is the selected tap divided by two.

Top module: `tap_window_sel`

## Requirements
- R1: After reset, tap_o and set_val_o are 0, and err_o, done_o, busy_o, set_tap_o and retune_en_o are all low.
- R2: Before scanning, a tap counts as passing only if result bit i and bit (i+N) mod 2N are both 1. A failure in either copy clears both copies.
- R3: The scan visits merged indices 0 to 2N−1 and keeps the longest run of passing bits. When runs are equally long, the run that started earliest is kept.
- R4: A run that is still open at index 2N−1 competes like any other run. Because the centre is reduced modulo N, a window that crosses from the first sweep into the second selects a valid tap.
- R5: When the best run spans indices s..e and is at least MIN_RUN long (3 by default), tap_o becomes ((s+e)/2) mod N, with the division truncating.
- R6: When the best run is shorter than MIN_RUN, err_o is high with done_o, and tap_o and set_val_o keep their previous values. err_o holds until the next done_o.
- R7: On success, set_tap_o and retune_en_o are high for exactly the single cycle in which done_o is high. They never go high on an error.
- R8: set_val_o equals tap_o when half_i was low at start, and tap_o shifted right by one when half_i was high at start.
- R9: If start_i is sampled at a clock edge while the block is idle, busy_o is high for the next 2N+1 cycles and done_o is high for one cycle, 2N+2 cycles after the start cycle. A start_i that arrives while busy_o is high is ignored.
- R10: A load_i issued while busy_o is high updates only the stored vector for the next start. It does not change the result of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture result_i into the stored vector |
| result_i | input | 2*NTAP | Pass/fail bits of both sweeps, 1 = pass |
| half_i | input | 1 | Halved-tap mode, sampled with start_i |
| start_i | input | 1 | Begin a selection from the stored vector |
| busy_o | output | 1 | Selection in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Last selection found no run long enough |
| tap_o | output | $clog2(NTAP) | Selected tap |
| set_val_o | output | $clog2(NTAP) | Tap value to apply |
| set_tap_o | output | 1 | Strobe: apply set_val_o |
| retune_en_o | output | 1 | Strobe: enable automatic re-tuning |

## Verification
The bench applies all 256 result vectors of a four-tap instance, each with a fresh vector loaded mid-scan and a spurious start. A design that skipped the merge would choose centres inside runs that one sweep failed. A design that missed the run still open at the end would report errors on all-pass vectors. A design without the modulo would emit out-of-range taps for windows that cross the sweep seam. The bench also catches a design that updated the tap on an error, let a mid-run load or start leak into the current result, or strobed done one cycle early or late.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_FINAL = 2'd2
  } tws_state_e;
endpackage

// File: rtl/tws_merge.sv
module tws_merge #(
  parameter int NTAP = 8,
  localparam int W = 2 * NTAP
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] merged_o
);
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign merged_o[g]        = raw_i[g] & raw_i[g+NTAP];
    assign merged_o[g+NTAP]   = raw_i[g] & raw_i[g+NTAP];
  end
endmodule

// File: rtl/tws_run_scan.sv
module tws_run_scan #(
  parameter int NTAP = 8,
  localparam int W  = 2 * NTAP,
  localparam int IW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic [W-1:0]  vec_i,
  input  logic          step_i,
  output logic [IW-1:0] idx_o,
  output logic [IW-1:0] len_o,
  output logic [IW-1:0] st_o,
  output logic [IW-1:0] end_o
);
  logic [W-1:0]  sh_q;
  logic [IW-1:0] run_q, best_q, bst_q, bend_q, idx_q;
  logic          longer;

  assign longer = run_q > best_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      run_q  <= '0;
      best_q <= '0;
      bst_q  <= '0;
      bend_q <= '0;
      idx_q  <= '0;
    end else if (init_i) begin
      sh_q   <= vec_i;
      run_q  <= '0;
      best_q <= '0;
      bst_q  <= '0;
      bend_q <= '0;
      idx_q  <= '0;
    end else if (step_i) begin
      sh_q  <= sh_q >> 1;
      idx_q <= idx_q + IW'(1);
      if (sh_q[0]) begin
        run_q <= run_q + IW'(1);
      end else begin
        // strict compare keeps the earliest of equal runs
        if (longer) begin
          best_q <= run_q;
          bst_q  <= idx_q - run_q;
          bend_q <= idx_q - IW'(1);
        end
        run_q <= '0;
      end
    end
  end

  // closed view: an open run competes as if a fail followed at idx_q
  assign idx_o = idx_q;
  assign len_o = longer ? run_q : best_q;
  assign st_o  = longer ? idx_q - run_q : bst_q;
  assign end_o = longer ? idx_q - IW'(1) : bend_q;

  AST_RUN_LE_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= idx_q); // R3
  AST_BEST_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i |=> best_q >= $past(best_q)); // R3
endmodule

// File: rtl/tws_tap_pick.sv
module tws_tap_pick #(
  parameter int NTAP    = 8,
  parameter int MIN_RUN = 3,
  localparam int W  = 2 * NTAP,
  localparam int IW = $clog2(W + 1),
  localparam int TW = (NTAP > 1) ? $clog2(NTAP) : 1
) (
  input  logic [IW-1:0] len_i,
  input  logic [IW-1:0] st_i,
  input  logic [IW-1:0] end_i,
  output logic          ok_o,
  output logic [TW-1:0] sel_o
);
  logic [IW:0] sum;
  logic [IW:0] mid;

  assign sum   = {1'b0, st_i} + {1'b0, end_i};
  assign mid   = sum >> 1;
  assign sel_o = TW'(mid % (IW+1)'(NTAP));
  assign ok_o  = 32'(len_i) >= MIN_RUN;
endmodule

// File: rtl/tap_window_sel.sv
module tap_window_sel
  import tws_pkg::*;
#(
  parameter int NTAP    = 8,
  parameter int MIN_RUN = 3,
  localparam int W  = 2 * NTAP,
  localparam int IW = $clog2(W + 1),
  localparam int TW = (NTAP > 1) ? $clog2(NTAP) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  result_i,
  input  logic          half_i,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [TW-1:0] tap_o,
  output logic [TW-1:0] set_val_o,
  output logic          set_tap_o,
  output logic          retune_en_o
);
  tws_state_e    state_q;
  logic [W-1:0]  vec_q, merged;
  logic          half_q, done_q, err_q, ok_q;
  logic [TW-1:0] tap_q, apply_q;
  logic          init, step, ok;
  logic [IW-1:0] idx, len, st, en;
  logic [TW-1:0] sel;

  assign init = (state_q == ST_IDLE) && start_i;
  assign step = (state_q == ST_SCAN);

  tws_merge #(.NTAP(NTAP)) u_merge (
    .raw_i    (vec_q),
    .merged_o (merged)
  );

  tws_run_scan #(.NTAP(NTAP)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (init),
    .vec_i  (merged),
    .step_i (step),
    .idx_o  (idx),
    .len_o  (len),
    .st_o   (st),
    .end_o  (en)
  );

  tws_tap_pick #(.NTAP(NTAP), .MIN_RUN(MIN_RUN)) u_pick (
    .len_i (len),
    .st_i  (st),
    .end_i (en),
    .ok_o  (ok),
    .sel_o (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= '0;
    else if (load_i) vec_q <= result_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      half_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ok_q    <= 1'b0;
      tap_q   <= '0;
      apply_q <= '0;
    end else begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          half_q  <= half_i;
          state_q <= ST_SCAN;
        end
        ST_SCAN: if (idx == IW'(W - 1)) state_q <= ST_FINAL;
        ST_FINAL: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
          if (ok) begin
            tap_q   <= sel;
            apply_q <= half_q ? (sel >> 1) : sel;
            ok_q    <= 1'b1;
            err_q   <= 1'b0;
          end else begin
            err_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign tap_o       = tap_q;
  assign set_val_o   = apply_q;
  assign set_tap_o   = ok_q;
  assign retune_en_o = ok_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_FROM_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(state_q == ST_FINAL)); // R9
  AST_SET_ON_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_tap_o |-> (done_o && !err_o)); // R7
  AST_ERR_HOLDS_TAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> ($stable(tap_o) && $stable(set_val_o))); // R6
  AST_TAP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tap_o) < NTAP); // R5
  AST_APPLY_LE_TAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_val_o <= tap_o); // R8
endmodule

// File: tb/tap_window_sel_bench.sv
module tap_window_sel_bench;
  localparam int N  = 4;
  localparam int W  = 2 * N;
  localparam int TW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic [W-1:0]  result_i = '0;
  logic          half_i = 1'b0;
  logic          start_i = 1'b0;
  logic          busy_o, done_o, err_o, set_tap_o, retune_en_o;
  logic [TW-1:0] tap_o, set_val_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [TW-1:0] exp_tap = '0;
  logic [TW-1:0] exp_apply = '0;

  always #10 clk_i = ~clk_i;

  tap_window_sel #(.NTAP(N)) u_tap_window_sel (
    .clk_i, .rst_ni, .load_i, .result_i, .half_i, .start_i,
    .busy_o, .done_o, .err_o, .tap_o, .set_val_o, .set_tap_o, .retune_en_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference: earliest longest run found by scanning every run start
  function automatic void model(input logic [W-1:0] v, output bit fail, output int tap);
    bit m[W];
    int best, bs, be;
    best = 0; bs = 0; be = 0;
    for (int i = 0; i < W; i++) m[i] = v[i] && v[(i + N) % W];
    for (int s = 0; s < W; s++) begin
      if (m[s] && (s == 0 || !m[s-1])) begin
        int l = 0;
        while (s + l < W && m[s+l]) l++;
        if (l > best) begin best = l; bs = s; be = s + l - 1; end
      end
    end
    fail = (best < 3);
    tap = ((bs + be) / 2) % N;
  endfunction

  task automatic run_one(input logic [W-1:0] v, input bit h);
    bit fail, tim_ok;
    int tap;
    model(v, fail, tap);
    @(negedge clk_i); load_i = 1'b1; result_i = v;
    @(negedge clk_i); load_i = 1'b0; start_i = 1'b1; half_i = h;
    tim_ok = 1'b1;
    for (int k = 1; k <= W + 2; k++) begin
      @(negedge clk_i);
      case (k)
        1: begin start_i = 1'b0; half_i = ~h; end
        2: start_i = 1'b1;                                  // R9 ignored while busy
        3: begin start_i = 1'b0; load_i = 1'b1; result_i = v ^ 8'h5A; end // R10
        4: load_i = 1'b0;
        default: ;
      endcase
      if (k <= W + 1) begin
        if (!busy_o || done_o || set_tap_o) tim_ok = 1'b0;
      end
    end
    if (!fail) begin
      exp_tap = TW'(tap);
      exp_apply = h ? TW'(tap >> 1) : TW'(tap);
    end
    check(tim_ok && done_o && !busy_o, "R9 done timing", int'(done_o), 1);
    check(err_o == fail, "R6 error flag", int'(err_o), int'(fail));
    check(tap_o == exp_tap, "R5 R10 selected tap", int'(tap_o), int'(exp_tap));
    check(set_val_o == exp_apply, "R8 applied value", int'(set_val_o), int'(exp_apply));
    check(set_tap_o == !fail && retune_en_o == !fail, "R7 strobes",
          int'(set_tap_o), int'(!fail));
    @(negedge clk_i);
    check(!done_o && !busy_o && !set_tap_o && !retune_en_o, "R7 R9 single pulse",
          int'(done_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(tap_o == 0 && set_val_o == 0, "R1 reset tap", int'(tap_o), 0);
    check(!err_o && !done_o && !busy_o && !set_tap_o && !retune_en_o,
          "R1 reset flags", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_one(8'hFE, 1'b0);
    check(tap_o == 2, "R2 one-sweep failure clears both copies", int'(tap_o), 2);
    run_one(8'h0F, 1'b0);
    check(err_o == 1, "R2 no tap passes both sweeps", int'(err_o), 1);
    run_one(8'hDD, 1'b1);
    check(tap_o == 3, "R3 longest run wins", int'(tap_o), 3);
    run_one(8'hFF, 1'b0);
    check(tap_o == 3, "R4 run open at end", int'(tap_o), 3);
    run_one(8'hBB, 1'b0);
    check(tap_o == 0, "R4 window across sweep seam", int'(tap_o), 0);

    for (int v = 0; v < 256; v++) run_one(W'(v), v[0] ^ v[3] ^ v[6]);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule